// File: doc/BRIEF.md
# Read and Write ID Allocator for a Level-Two Master Port

This block hands out AXI transaction IDs for the level-two master port of a processor and keeps track of every ID that is still in flight. Three read requesters compete for the read address channel. Data-side uncached loads always use ID 0. Instruction fetches, cached or not, always use ID 1. Data-side linefills draw from a pool of five IDs, 3 to 7. ID 2 is left unused. A requester is held off while its ID is still in flight. An ID is returned when the final read beat of its transaction is accepted.

On the write side, each request is tagged by class. Uncached writes and write-through writes go out on ID 0, and evictions go out on ID 1. The block queues the address and the data of each accepted write separately. A later write can therefore present its address while an earlier write is still moving data. Data bursts always leave whole and in order. A write slot is returned when the write response arrives. The data path, the cache lookup and the slave lie outside this block.

Top module: `axi_id_alloc`

## Requirements
- R1: An uncached data read is granted only with read ID 0, and its address goes out with `ar_id` = 0.
- R2: An instruction fetch is granted only with read ID 1, and its address goes out with `ar_id` = 1.
- R3: A linefill is granted the lowest free ID in 3..7, which is reported on `lf_req_id` in the grant cycle. When all five are busy the linefill is stalled. ID 2 is never issued.
- R4: A read ID is busy from its grant until the cycle in which `r_valid`, `r_ready` and `r_last` are all high with that `r_id`. No request is granted on a busy ID. An ID freed in a cycle can be granted from the following cycle, but not in that cycle.
- R5: At most one read is granted per cycle, with fixed priority: uncached data, then fetch, then linefill. A grant happens only when the address register is empty or is handing off in that cycle. `ar_valid` rises the cycle after a grant, and `ar_id` holds steady while the slave stalls.
- R6: A write with `wr_req_evict` = 1 goes out with `aw_id` = 1, and any other write goes out with `aw_id` = 0. `aw_len` carries `wr_req_len`, which is the beat count minus one. Addresses leave in acceptance order and hold steady while stalled.
- R7: A write request is accepted when all three of these hold: the address queue has room, the data queue has room, and the number of outstanding writes on its ID is below `WOUT_MAX` (default 2). Each queue is 2 deep, and a slot released in the same cycle counts as room.
- R8: Data bursts leave in acceptance order, with `w_id` naming the write. `w_last` is high on beat `len`+1, counting from 1. A burst is never interleaved with another. A later write may present its address before an earlier write's data has finished.
- R9: A `b_valid` pulse on `b_id` releases one outstanding write slot on that ID from the next cycle. The slave may respond only after both the address and the last data beat of that write have been sent.
- R10: After reset no address or data is presented, all IDs are free and no write slot is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dnc_req_valid | input | 1 | Uncached data read request, held until granted |
| dnc_req_ready | output | 1 | Grant for the uncached data read |
| if_req_valid | input | 1 | Instruction fetch request, held until granted |
| if_req_ready | output | 1 | Grant for the fetch |
| lf_req_valid | input | 1 | Data linefill request, held until granted |
| lf_req_ready | output | 1 | Grant for the linefill |
| lf_req_id | output | 3 | ID given to the linefill, valid with its grant |
| ar_valid | output | 1 | Read address valid |
| ar_ready | input | 1 | Read address accepted by the slave |
| ar_id | output | 3 | Read ID |
| r_valid | input | 1 | Read data beat valid |
| r_ready | input | 1 | Read data beat taken by the data path |
| r_last | input | 1 | Final beat of a read |
| r_id | input | 3 | ID of the read beat |
| wr_req_valid | input | 1 | Write request, held until accepted |
| wr_req_evict | input | 1 | 1 for an eviction, 0 for an uncached or write-through write |
| wr_req_len | input | 4 | Beats minus one |
| wr_req_ready | output | 1 | Write request accepted |
| aw_valid | output | 1 | Write address valid |
| aw_ready | input | 1 | Write address accepted |
| aw_id | output | 1 | Write ID |
| aw_len | output | 4 | Burst length minus one |
| w_valid | output | 1 | Write data beat valid |
| w_ready | input | 1 | Write data beat accepted |
| w_id | output | 1 | Write the current beat belongs to |
| w_last | output | 1 | Final beat of the burst |
| b_valid | input | 1 | Write response, always taken |
| b_id | input | 1 | ID of the write response |

## Verification
Two collisions matter on the read side. A final read beat can free an ID in the same cycle that a held request wants that ID. This is forced by filling the linefill pool while a linefill stays pending, then returning last beats under random `r_ready`. The grant must wait exactly one cycle and must then take the lowest freed ID. On the write side, an address hand-off, the end of a data burst and a new acceptance can all land in one cycle. Random `aw_ready` and `w_ready` provoke this, and a queue-based model judges `wr_req_ready` and the order of the presented address and data on every clock.

// File: rtl/axi_idq_pkg.sv
package axi_idq_pkg;
  localparam int RID_W    = 3;
  localparam int RD_SLOTS = 1 << RID_W;
  localparam int WID_W    = 1;
  localparam int WR_SLOTS = 1 << WID_W;

  localparam logic [RID_W-1:0] RID_DNC    = 3'd0;
  localparam logic [RID_W-1:0] RID_IFETCH = 3'd1;
  localparam logic [RID_W-1:0] RID_GAP    = 3'd2;
  localparam int LF_LO = 3;
  localparam int LF_HI = 7;

  localparam logic [WID_W-1:0] WID_PLAIN = 1'b0;
  localparam logic [WID_W-1:0] WID_EVICT = 1'b1;

  typedef enum logic [1:0] {SRC_NONE, SRC_DNC, SRC_IFETCH, SRC_LF} rd_src_e;

  typedef struct packed {
    logic             found;
    logic [RID_W-1:0] id;
  } lf_slot_t;

  // lowest idle member of the linefill pool
  function automatic lf_slot_t lf_lowest_free(input logic [RD_SLOTS-1:0] busy);
    lf_slot_t res;
    res = '0;
    for (int i = LF_HI; i >= LF_LO; i--) begin
      if (!busy[i]) begin
        res.found = 1'b1;
        res.id    = RID_W'(i);
      end
    end
    return res;
  endfunction

  function automatic logic [WID_W-1:0] wr_class_id(input logic evict);
    return evict ? WID_EVICT : WID_PLAIN;
  endfunction

  // one-hot mask for an ID, empty when not enabled
  function automatic logic [RD_SLOTS-1:0] rid_mask(input logic en, input logic [RID_W-1:0] id);
    return en ? (RD_SLOTS'(1) << id) : '0;
  endfunction
endpackage

// File: rtl/idq_fifo.sv
module idq_fifo #(
  parameter int DEPTH = 2,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic         empty,
  output logic         full,
  output logic [W-1:0] head
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign head  = mem[rd_q];

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= bump(wr_q);
      if (pop)  rd_q <= bump(rd_q);
      cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/rid_tracker.sv
module rid_tracker
  import axi_idq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dnc_valid,
  output logic             dnc_ready,
  input  logic             ifetch_valid,
  output logic             ifetch_ready,
  input  logic             lf_valid,
  output logic             lf_ready,
  output logic [RID_W-1:0] lf_id,
  output logic             ar_valid,
  output logic [RID_W-1:0] ar_id,
  input  logic             ar_ready,
  input  logic             r_valid,
  input  logic             r_ready,
  input  logic             r_last,
  input  logic [RID_W-1:0] r_id
);
  logic [RD_SLOTS-1:0] busy_q, set_vec, clr_vec;
  logic                slot_open, r_done;
  lf_slot_t            lf_slot;
  rd_src_e             sel;
  logic [RID_W-1:0]    sel_id;

  always_comb begin
    slot_open = !ar_valid || ar_ready;
    lf_slot   = lf_lowest_free(busy_q);
    sel       = SRC_NONE;
    sel_id    = '0;
    if (slot_open) begin
      if (dnc_valid && !busy_q[RID_DNC]) begin
        sel    = SRC_DNC;
        sel_id = RID_DNC;
      end else if (ifetch_valid && !busy_q[RID_IFETCH]) begin
        sel    = SRC_IFETCH;
        sel_id = RID_IFETCH;
      end else if (lf_valid && lf_slot.found) begin
        sel    = SRC_LF;
        sel_id = lf_slot.id;
      end
    end
  end

  assign dnc_ready    = (sel == SRC_DNC);
  assign ifetch_ready = (sel == SRC_IFETCH);
  assign lf_ready     = (sel == SRC_LF);
  assign lf_id        = lf_slot.id;

  assign r_done  = r_valid && r_ready && r_last;
  assign set_vec = rid_mask(sel != SRC_NONE, sel_id);
  assign clr_vec = rid_mask(r_done, r_id);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= '0;
      ar_valid <= 1'b0;
      ar_id    <= '0;
    end else begin
      busy_q <= (busy_q & ~clr_vec) | set_vec;
      if (sel != SRC_NONE) begin
        ar_valid <= 1'b1;
        ar_id    <= sel_id;
      end else if (ar_ready) begin
        ar_valid <= 1'b0;
      end
    end
  end

  assert_gap_id_unused_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid |-> (ar_id != RID_GAP));
  assert_free_only_inflight_R4: assert property (@(posedge clk) disable iff (!rst_n)
    r_done |-> busy_q[r_id]);
  assert_no_duplicate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ($countones(busy_q) ==
                    $past($countones(busy_q)) + 1 - int'($past(r_done))));
  assert_ar_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_valid && !ar_ready) |=> (ar_valid && $stable(ar_id)));
  assert_lf_grant_pool_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lf_ready |-> (lf_id >= RID_W'(LF_LO)));
endmodule

// File: rtl/wr_seq.sv
module wr_seq
  import axi_idq_pkg::*;
#(
  parameter int LEN_W    = 4,
  parameter int WOUT_MAX = 2,
  parameter int Q_DEPTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic             wr_evict,
  input  logic [LEN_W-1:0] wr_len,
  output logic             wr_ready,
  output logic             aw_valid,
  output logic [WID_W-1:0] aw_id,
  output logic [LEN_W-1:0] aw_len,
  input  logic             aw_ready,
  output logic             w_valid,
  output logic [WID_W-1:0] w_id,
  output logic             w_last,
  input  logic             w_ready,
  input  logic             b_valid,
  input  logic [WID_W-1:0] b_id
);
  localparam int ENT_W = WID_W + LEN_W;
  localparam int CNT_W = $clog2(WOUT_MAX + 1);

  logic [WID_W-1:0] req_id;
  logic [ENT_W-1:0] req_ent, aw_head, w_head;
  logic             aw_empty, aw_full, w_empty, w_full;
  logic             aw_pop, w_fire, w_pop, accept;
  logic [LEN_W-1:0] beat_q, w_len;
  logic [CNT_W-1:0] wout_q    [WR_SLOTS];
  logic [CNT_W-1:0] aw_done_q [WR_SLOTS];
  logic [CNT_W-1:0] w_done_q  [WR_SLOTS];

  assign req_id  = wr_class_id(wr_evict);
  assign req_ent = {req_id, wr_len};

  assign aw_valid = !aw_empty;
  assign aw_id    = aw_head[ENT_W-1 -: WID_W];
  assign aw_len   = aw_head[LEN_W-1:0];
  assign aw_pop   = aw_valid && aw_ready;

  assign w_valid = !w_empty;
  assign w_id    = w_head[ENT_W-1 -: WID_W];
  assign w_len   = w_head[LEN_W-1:0];
  assign w_last  = (beat_q == w_len);
  assign w_fire  = w_valid && w_ready;
  assign w_pop   = w_fire && w_last;

  assign accept = wr_valid && (!aw_full || aw_pop) && (!w_full || w_pop) &&
                  (wout_q[req_id] < CNT_W'(WOUT_MAX));
  assign wr_ready = accept;

  idq_fifo #(.DEPTH(Q_DEPTH), .W(ENT_W)) u_aw_q (
    .clk(clk), .rst_n(rst_n), .push(accept), .din(req_ent), .pop(aw_pop),
    .empty(aw_empty), .full(aw_full), .head(aw_head));

  idq_fifo #(.DEPTH(Q_DEPTH), .W(ENT_W)) u_w_q (
    .clk(clk), .rst_n(rst_n), .push(accept), .din(req_ent), .pop(w_pop),
    .empty(w_empty), .full(w_full), .head(w_head));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     beat_q <= '0;
    else if (w_pop) beat_q <= '0;
    else if (w_fire) beat_q <= beat_q + 1'b1;
  end

  for (genvar g = 0; g < WR_SLOTS; g++) begin : g_slot
    logic rel;
    assign rel = b_valid && (b_id == WID_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wout_q[g]    <= '0;
        aw_done_q[g] <= '0;
        w_done_q[g]  <= '0;
      end else begin
        wout_q[g]    <= wout_q[g] + CNT_W'(accept && (req_id == WID_W'(g))) - CNT_W'(rel);
        aw_done_q[g] <= aw_done_q[g] + CNT_W'(aw_pop && (aw_id == WID_W'(g))) - CNT_W'(rel);
        w_done_q[g]  <= w_done_q[g] + CNT_W'(w_pop && (w_id == WID_W'(g))) - CNT_W'(rel);
      end
    end
  end

  assert_aw_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_valid && !aw_ready) |=> (aw_valid && $stable(aw_id) && $stable(aw_len)));
  assert_w_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (w_valid && !w_ready) |=> (w_valid && $stable(w_id) && $stable(w_last)));
  assert_no_interleave_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (w_fire && !w_last) |=> (w_valid && (w_id == $past(w_id))));
  assert_resp_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    b_valid |-> ((aw_done_q[b_id] != '0) && (w_done_q[b_id] != '0)));
  assert_slot_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (wout_q[req_id] != CNT_W'(WOUT_MAX)));
endmodule

// File: rtl/axi_id_alloc.sv
module axi_id_alloc
  import axi_idq_pkg::*;
#(
  parameter int LEN_W    = 4,
  parameter int WOUT_MAX = 2,
  parameter int Q_DEPTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dnc_req_valid,
  output logic             dnc_req_ready,
  input  logic             if_req_valid,
  output logic             if_req_ready,
  input  logic             lf_req_valid,
  output logic             lf_req_ready,
  output logic [RID_W-1:0] lf_req_id,
  output logic             ar_valid,
  input  logic             ar_ready,
  output logic [RID_W-1:0] ar_id,
  input  logic             r_valid,
  input  logic             r_ready,
  input  logic             r_last,
  input  logic [RID_W-1:0] r_id,
  input  logic             wr_req_valid,
  input  logic             wr_req_evict,
  input  logic [LEN_W-1:0] wr_req_len,
  output logic             wr_req_ready,
  output logic             aw_valid,
  input  logic             aw_ready,
  output logic [WID_W-1:0] aw_id,
  output logic [LEN_W-1:0] aw_len,
  output logic             w_valid,
  input  logic             w_ready,
  output logic [WID_W-1:0] w_id,
  output logic             w_last,
  input  logic             b_valid,
  input  logic [WID_W-1:0] b_id
);
  rid_tracker u_rd (
    .clk(clk), .rst_n(rst_n),
    .dnc_valid(dnc_req_valid), .dnc_ready(dnc_req_ready),
    .ifetch_valid(if_req_valid), .ifetch_ready(if_req_ready),
    .lf_valid(lf_req_valid), .lf_ready(lf_req_ready), .lf_id(lf_req_id),
    .ar_valid(ar_valid), .ar_id(ar_id), .ar_ready(ar_ready),
    .r_valid(r_valid), .r_ready(r_ready), .r_last(r_last), .r_id(r_id));

  wr_seq #(.LEN_W(LEN_W), .WOUT_MAX(WOUT_MAX), .Q_DEPTH(Q_DEPTH)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_req_valid), .wr_evict(wr_req_evict), .wr_len(wr_req_len),
    .wr_ready(wr_req_ready),
    .aw_valid(aw_valid), .aw_id(aw_id), .aw_len(aw_len), .aw_ready(aw_ready),
    .w_valid(w_valid), .w_id(w_id), .w_last(w_last), .w_ready(w_ready),
    .b_valid(b_valid), .b_id(b_id));
endmodule

// File: tb/test_axi_id_alloc.sv
module test_axi_id_alloc;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic dnc_req_valid, dnc_req_ready, if_req_valid, if_req_ready;
  logic lf_req_valid, lf_req_ready;
  logic [2:0] lf_req_id, ar_id, r_id;
  logic ar_valid, ar_ready, r_valid, r_ready, r_last;
  logic wr_req_valid, wr_req_evict, wr_req_ready;
  logic [3:0] wr_req_len, aw_len;
  logic aw_valid, aw_ready, w_valid, w_ready, w_last, b_valid;
  logic [0:0] aw_id, w_id, b_id;

  axi_id_alloc i_axi_id_alloc (.*);

  int total = 0, bad = 0;
  bit done = 0;

  // reference state
  bit m_busy[8];
  bit m_arv;
  int m_arid;
  int m_awq[$], m_wq[$];
  int m_beat;
  int m_wout[2];
  bit rfl[8];
  int s_aw[2], s_w[2];
  int seen[$];
  int ev_aw_ahead = 0, ev_collide = 0;
  bit f_dnc, f_if, f_lf, f_wr, f_r;
  int p_dnc, p_if, p_lf, p_wr, p_ar, p_aw, p_w, p_r, p_rr, p_b;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit rnd(input int p);
    return int'($urandom % 100) < p;
  endfunction

  task automatic step();
    int pick, src;
    bit open, awpop, wpop, acc, wl;
    int cls, wlen;
    @(negedge clk);
    if (f_dnc) dnc_req_valid = 0;
    if (f_if)  if_req_valid = 0;
    if (f_lf)  lf_req_valid = 0;
    if (f_wr)  wr_req_valid = 0;
    if (f_r)   r_valid = 0;
    f_dnc = 0; f_if = 0; f_lf = 0; f_wr = 0; f_r = 0;
    b_valid = 0;
    if (!dnc_req_valid && rnd(p_dnc)) dnc_req_valid = 1;
    if (!if_req_valid && rnd(p_if))   if_req_valid = 1;
    if (!lf_req_valid && rnd(p_lf))   lf_req_valid = 1;
    if (!wr_req_valid && rnd(p_wr)) begin
      wr_req_valid = 1;
      wr_req_evict = rnd(50);
      wr_req_len   = 4'($urandom % 4);
    end
    ar_ready = rnd(p_ar); aw_ready = rnd(p_aw); w_ready = rnd(p_w); r_ready = rnd(p_rr);
    if (!r_valid && rnd(p_r)) begin
      int st = int'($urandom % 8);
      for (int k = 0; k < 8; k++) begin
        int j = (st + k) % 8;
        if (rfl[j]) begin
          r_valid = 1; r_id = 3'(j); r_last = rnd(60);
          break;
        end
      end
    end
    if (rnd(p_b)) begin
      int st = int'($urandom % 2);
      for (int k = 0; k < 2; k++) begin
        int j = (st + k) % 2;
        if (s_aw[j] > 0 && s_w[j] > 0) begin
          b_valid = 1; b_id = 1'(j);
          break;
        end
      end
    end
    #1;
    // ---- read side expectation
    open = !m_arv || ar_ready;
    pick = -1; src = 0;
    if (open) begin
      if (dnc_req_valid && !m_busy[0]) begin pick = 0; src = 1; end
      else if (if_req_valid && !m_busy[1]) begin pick = 1; src = 2; end
      else if (lf_req_valid) begin
        for (int k = 3; k < 8; k++) if (!m_busy[k]) begin pick = k; src = 3; break; end
      end
    end
    if (lf_req_valid && open && !dnc_req_valid && !if_req_valid && r_valid && r_ready && r_last
        && pick < 0 && r_id >= 3) ev_collide++;
    chk(dnc_req_ready == (src == 1), "R1 uncached grant", dnc_req_ready, src == 1);
    chk(if_req_ready == (src == 2), "R2 fetch grant", if_req_ready, src == 2);
    chk(lf_req_ready == (src == 3), "R3 linefill grant", lf_req_ready, src == 3);
    if (src == 3) chk(int'(lf_req_id) == pick, "R3 linefill id", lf_req_id, pick);
    if (lf_req_ready) chk(!m_busy[lf_req_id], "R4 grant on busy id", lf_req_id, -1);
    chk(ar_valid == m_arv, "R5 ar_valid", ar_valid, m_arv);
    if (m_arv) chk(int'(ar_id) == m_arid, "R5 ar_id", ar_id, m_arid);
    // ---- write side expectation
    awpop = (m_awq.size() > 0) && aw_ready;
    wlen = (m_wq.size() > 0) ? (m_wq[0] % 16) : -1;
    wl = (m_beat == wlen);
    wpop = (m_wq.size() > 0) && w_ready && wl;
    cls = wr_req_evict ? 1 : 0;
    acc = wr_req_valid && (m_awq.size() < 2 || awpop) && (m_wq.size() < 2 || wpop) && m_wout[cls] < 2;
    chk(wr_req_ready == acc, "R7 write accept", wr_req_ready, acc);
    chk(aw_valid == (m_awq.size() > 0), "R6 aw_valid", aw_valid, m_awq.size() > 0);
    if (m_awq.size() > 0) begin
      chk(int'(aw_id) == m_awq[0] / 16, "R6 aw_id", aw_id, m_awq[0] / 16);
      chk(int'(aw_len) == m_awq[0] % 16, "R6 aw_len", aw_len, m_awq[0] % 16);
    end
    chk(w_valid == (m_wq.size() > 0), "R8 w_valid", w_valid, m_wq.size() > 0);
    if (m_wq.size() > 0) begin
      chk(int'(w_id) == m_wq[0] / 16, "R8 w_id", w_id, m_wq[0] / 16);
      chk(w_last == wl, "R8 w_last", w_last, wl);
    end
    // ---- advance the reference (the edge that follows)
    if (dnc_req_ready) f_dnc = 1;
    if (if_req_ready)  f_if = 1;
    if (lf_req_ready)  f_lf = 1;
    if (wr_req_ready)  f_wr = 1;
    if (r_valid && r_ready) begin
      f_r = 1;
      if (r_last) begin rfl[r_id] = 0; m_busy[r_id] = 0; end
    end
    if (m_arv && ar_ready) begin rfl[m_arid] = 1; seen.push_back(m_arid); end
    if (pick >= 0) begin m_busy[pick] = 1; m_arv = 1; m_arid = pick; end
    else if (ar_ready) m_arv = 0;
    if (awpop) begin
      if (m_wq.size() > m_awq.size()) ev_aw_ahead++;
      s_aw[m_awq[0] / 16]++;
      void'(m_awq.pop_front());
    end
    if ((m_wq.size() > 0) && w_ready) begin
      if (wl) begin s_w[m_wq[0] / 16]++; void'(m_wq.pop_front()); m_beat = 0; end
      else m_beat++;
    end
    if (acc) begin
      m_awq.push_back(cls * 16 + int'(wr_req_len));
      m_wq.push_back(cls * 16 + int'(wr_req_len));
      m_wout[cls]++;
    end
    if (b_valid) begin s_aw[b_id]--; s_w[b_id]--; m_wout[b_id]--; end
  endtask

  task automatic knobs(input int d, input int i, input int l, input int w, input int ar,
                       input int aw, input int wr, input int r, input int rr, input int b);
    p_dnc = d; p_if = i; p_lf = l; p_wr = w; p_ar = ar;
    p_aw = aw; p_w = wr; p_r = r; p_rr = rr; p_b = b;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 0;
    dnc_req_valid = 0; if_req_valid = 0; lf_req_valid = 0; wr_req_valid = 0;
    wr_req_evict = 0; wr_req_len = '0;
    ar_ready = 0; aw_ready = 0; w_ready = 0; r_valid = 0; r_ready = 0; r_last = 0; r_id = '0;
    b_valid = 0; b_id = '0;
    knobs(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R10: idle after reset
    chk(!ar_valid, "R10 ar_valid after reset", ar_valid, 0);
    chk(!aw_valid, "R10 aw_valid after reset", aw_valid, 0);
    chk(!w_valid, "R10 w_valid after reset", w_valid, 0);

    // R3: pool fills lowest first and then stalls
    knobs(0, 0, 100, 0, 100, 100, 100, 0, 100, 0);
    repeat (12) step();
    chk(seen.size() == 5, "R3 pool size", seen.size(), 5);
    for (int k = 0; k < 5 && k < seen.size(); k++)
      chk(seen[k] == k + 3, "R3 pool order", seen[k], k + 3);
    chk(!lf_req_ready && lf_req_valid, "R3 sixth linefill stalled", lf_req_ready, 0);
    seen.delete();

    // R4: free a pool ID while a linefill waits
    knobs(0, 0, 100, 0, 100, 100, 100, 100, 100, 0);
    repeat (40) step();

    // R1/R2/R5/R6..R9: random traffic under back-pressure
    for (int ph = 0; ph < 6; ph++) begin
      knobs(30, 30, 50, 60, 20 + ph * 15, 30 + ph * 10, 40 + ph * 10, 50, 40 + ph * 10, 40);
      repeat (500) step();
    end

    // drain
    knobs(0, 0, 0, 0, 100, 100, 100, 100, 100, 100);
    repeat (200) step();
    chk(!ar_valid, "R4 read side idle after drain", ar_valid, 0);
    chk(!aw_valid && !w_valid, "R8 write side idle after drain", aw_valid | w_valid, 0);
    chk(ev_aw_ahead > 0, "R8 address ahead of earlier data", ev_aw_ahead, 1);
    chk(ev_collide > 0, "R4 free and request in one cycle", ev_collide, 1);

    // R3: all freed, pool restarts at its lowest ID
    knobs(0, 0, 100, 0, 100, 100, 100, 0, 100, 0);
    @(negedge clk);
    lf_req_valid = 1;
    #1;
    chk(lf_req_ready && lf_req_id == 3'd3, "R3 pool restarts at lowest", lf_req_id, 3);
    finish_run();
  end
endmodule